// File: doc/BRIEF.md
# Battery-Backed Configuration RAM with Rolling Checksum

This block is the general-purpose byte store that sits next to a real-time clock. The host reaches it through two byte registers. The index register selects a location. The data register reads or writes the byte at that location. A ninth index bit, supplied beside the byte on index writes, selects one of two 128-byte banks. The lower bank serves locations 0x0E to 0x7F; the clock registers below 0x0E belong elsewhere. The upper bank serves locations 0x80 to 0xFF.

A range of configuration bytes in the lower bank is protected by a 16-bit checksum, and the block keeps that checksum in two further bytes of the lower bank. Any host write into the protected range starts a recompute without further action. A recompute reads the range one byte per clock, adds the bytes up and writes the result back. The `recalc` input forces the same recompute, for example after power-up or after the RAM contents have been restored. The storage is a dual-port memory that maps onto block RAM. The host uses one port and the checksum engine uses the other.

Top module: `cmos_nvram`

## Requirements
- R1: After a synchronous reset, `host_rdata` is 0x00, `host_err` is 0 and `busy` is 0.
- R2: A data-register write followed by a data-register read at the same index returns the written byte. `host_rdata` changes on the clock edge that samples `host_rd` and then holds until the next read.
- R3: Index writes (`host_wr`=1, `host_sel`=0) load index bits 7:0 from `host_wdata` and index bit 8 from `host_hi_idx`. The valid index ranges are bit 8 = 0 with low byte 0x0E..0x7F, and bit 8 = 1 with low byte 0x80..0xFF. Every valid location stores its own byte.
- R4: A data access (`host_sel`=1 write, or any `host_rd`) at an invalid index sets `host_err` to 1. A write at an invalid index changes no stored byte and starts no recompute. A read at an invalid index returns 0xFF. A data access at a valid index sets `host_err` to 0, and `host_err` holds its value between data accesses.
- R5: Once a recompute finishes, the byte at lower-bank 0x2E holds bits 15:8 and the byte at 0x2F holds bits 7:0 of the 16-bit wrap-around sum of the lower-bank bytes 0x10 through 0x2D.
- R6: A write at a valid index outside lower-bank 0x10..0x2D starts no recompute. `busy` stays 0, and 0x2E/0x2F keep their values unless that write targets them.
- R7: A recompute started on an idle block keeps `busy` at 1 for exactly 33 cycles. That is 30 read cycles plus one accumulate cycle and two write-back cycles, counted from the edge that accepts the trigger.
- R8: A one-cycle pulse on `recalc` starts a full recompute, and a host write to 0x2E/0x2F made while idle is then replaced by the correct checksum.
- R9: A host write to 0x2E or 0x2F while `busy` is 1 is discarded, and the checksum result ends up in those bytes.
- R10: A write into 0x10..0x2D while a recompute is running restarts the sum, so the final checksum includes the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Write strobe for the register selected by host_sel |
| host_rd | input | 1 | Data read strobe at the current index |
| host_sel | input | 1 | 0 = index register, 1 = data register (writes only) |
| host_hi_idx | input | 1 | Bank bit (index bit 8), loaded on index writes |
| host_wdata | input | 8 | Write byte: index low byte or data |
| recalc | input | 1 | Pulse to force a full checksum recompute |
| host_rdata | output | 8 | Registered read byte |
| host_err | output | 1 | Last data access used an invalid index |
| busy | output | 1 | Checksum recompute in progress |

## Verification
The hardest states to reach from the ports are the ones where host traffic and a running recompute interfere. The bench starts a recompute and then, while `busy` is still high, lands writes on the checksum bytes and on bytes inside the protected range. It checks that the late window write restarts the sum and that the checksum-byte write is overwritten. Invalid indices are chosen so that their low byte aliases a real location in the other bank. Reading that location back shows at the ports that nothing was disturbed. The expected checksums come from a byte model kept in the bench.

// File: rtl/cmos_nvram_pkg.sv
package cmos_nvram_pkg;
  typedef enum logic [2:0] {
    ENG_IDLE,
    ENG_SUM,
    ENG_LAST,
    ENG_WHI,
    ENG_WLO
  } eng_st_t;
endpackage

// File: rtl/cmos_idx_decode.sv
module cmos_idx_decode #(
  parameter int IDX_W   = 9,
  parameter int AW      = 8,
  parameter int A_FIRST = 'h0E,
  parameter int B_FIRST = 'h80,
  parameter int WIN_LO  = 'h10,
  parameter int WIN_HI  = 'h2D,
  parameter int CK_HI   = 'h2E,
  parameter int CK_LO   = 'h2F
) (
  input  logic [IDX_W-1:0] idx,
  output logic             valid,
  output logic             in_window,
  output logic             is_ck,
  output logic [AW-1:0]    ram_addr
);
  localparam logic [AW-1:0] A_LO = AW'(A_FIRST);
  localparam logic [AW-1:0] B_LO = AW'(B_FIRST);
  localparam logic [AW-1:0] W_LO = AW'(WIN_LO);
  localparam logic [AW-1:0] W_HI = AW'(WIN_HI);
  localparam logic [AW-1:0] K_HI = AW'(CK_HI);
  localparam logic [AW-1:0] K_LO = AW'(CK_LO);

  logic          upper;
  logic [AW-1:0] low;

  always_comb begin
    upper     = idx[IDX_W-1];
    low       = idx[AW-1:0];
    ram_addr  = low;
    if (upper) valid = (low >= B_LO);
    else       valid = (low >= A_LO) && (low < B_LO);
    in_window = !upper && (low >= W_LO) && (low <= W_HI);
    is_ck     = !upper && ((low == K_HI) || (low == K_LO));
  end
endmodule

// File: rtl/cmos_dpram.sv
module cmos_dpram #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          a_we,
  input  logic          a_re,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_we,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
  end

  always_ff @(posedge clk) begin
    if (rst)       a_rdata <= '0;
    else if (a_re) a_rdata <= mem[a_addr];
  end

  always_ff @(posedge clk) begin
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/cmos_csum_engine.sv
module cmos_csum_engine
  import cmos_nvram_pkg::*;
#(
  parameter int DW     = 8,
  parameter int AW     = 8,
  parameter int WIN_LO = 'h10,
  parameter int WIN_HI = 'h2D,
  parameter int CK_HI  = 'h2E,
  parameter int CK_LO  = 'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy
);
  localparam int SW = 2 * DW;
  localparam logic [AW-1:0] W_LO = AW'(WIN_LO);
  localparam logic [AW-1:0] W_HI = AW'(WIN_HI);
  localparam logic [AW-1:0] K_HI = AW'(CK_HI);
  localparam logic [AW-1:0] K_LO = AW'(CK_LO);

  eng_st_t       st;
  logic [AW-1:0] ptr;
  logic [SW-1:0] acc;
  logic          vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ENG_IDLE;
      ptr <= '0;
      acc <= '0;
      vld <= 1'b0;
    end else begin
      vld <= (st == ENG_SUM) && !start;
      if (start) begin
        st  <= ENG_SUM;
        ptr <= W_LO;
        acc <= '0;
      end else begin
        if (vld) acc <= acc + SW'(rd_data);
        case (st)
          ENG_SUM: begin
            if (ptr == W_HI) st <= ENG_LAST;
            else             ptr <= ptr + 1'b1;
          end
          ENG_LAST: st <= ENG_WHI;
          ENG_WHI:  st <= ENG_WLO;
          default:  st <= ENG_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    busy    = (st != ENG_IDLE);
    rd_addr = ptr;
    wr_en   = (st == ENG_WHI) || (st == ENG_WLO);
    wr_addr = (st == ENG_WHI) ? K_HI : K_LO;
    wr_data = (st == ENG_WHI) ? acc[SW-1:DW] : acc[DW-1:0];
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |=> busy); // R8
  AST_PTR_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    (st == ENG_SUM) |-> ((ptr >= W_LO) && (ptr <= W_HI))); // R5
  AST_DONE_AFTER_WLO: assert property (@(posedge clk) disable iff (rst)
    ((st == ENG_WLO) && !start) |=> !busy); // R7
  AST_LAST_TO_WRITE: assert property (@(posedge clk) disable iff (rst)
    ((st == ENG_LAST) && !start) |=> wr_en); // R5
endmodule

// File: rtl/cmos_nvram.sv
module cmos_nvram #(
  parameter int DW      = 8,
  parameter int AW      = 8,
  parameter int IDX_W   = AW + 1,
  parameter int A_FIRST = 'h0E,
  parameter int B_FIRST = 'h80,
  parameter int WIN_LO  = 'h10,
  parameter int WIN_HI  = 'h2D,
  parameter int CK_HI   = 'h2E,
  parameter int CK_LO   = 'h2F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic          host_sel,
  input  logic          host_hi_idx,
  input  logic [DW-1:0] host_wdata,
  input  logic          recalc,
  output logic [DW-1:0] host_rdata,
  output logic          host_err,
  output logic          busy
);
  logic [IDX_W-1:0] idx_q;
  logic             idx_valid, idx_win, idx_ck;
  logic [AW-1:0]    ram_addr;
  logic             data_wr, data_rd, data_acc;
  logic             a_we, start;
  logic             rd_bad_q;
  logic [DW-1:0]    a_q;
  logic [AW-1:0]    e_raddr, e_waddr;
  logic [DW-1:0]    e_rdata, e_wdata;
  logic             e_we;

  cmos_idx_decode #(
    .IDX_W(IDX_W), .AW(AW), .A_FIRST(A_FIRST), .B_FIRST(B_FIRST),
    .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .CK_HI(CK_HI), .CK_LO(CK_LO)
  ) dec_i (
    .idx(idx_q), .valid(idx_valid), .in_window(idx_win),
    .is_ck(idx_ck), .ram_addr(ram_addr)
  );

  always_comb begin
    data_wr  = host_wr && host_sel;
    data_rd  = host_rd && !host_wr;
    data_acc = data_wr || data_rd;
    a_we     = data_wr && idx_valid && !(idx_ck && busy);
    start    = recalc || (data_wr && idx_valid && idx_win);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q    <= '0;
      host_err <= 1'b0;
      rd_bad_q <= 1'b0;
    end else begin
      if (host_wr && !host_sel) idx_q <= {host_hi_idx, host_wdata};
      if (data_acc) host_err <= !idx_valid;
      if (data_rd)  rd_bad_q <= !idx_valid;
    end
  end

  cmos_dpram #(.DW(DW), .AW(AW)) ram_i (
    .clk(clk), .rst(rst),
    .a_we(a_we), .a_re(data_rd && idx_valid), .a_addr(ram_addr),
    .a_wdata(host_wdata), .a_rdata(a_q),
    .b_we(e_we), .b_addr(e_we ? e_waddr : e_raddr),
    .b_wdata(e_wdata), .b_rdata(e_rdata)
  );

  cmos_csum_engine #(
    .DW(DW), .AW(AW), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI),
    .CK_HI(CK_HI), .CK_LO(CK_LO)
  ) eng_i (
    .clk(clk), .rst(rst), .start(start),
    .rd_addr(e_raddr), .rd_data(e_rdata),
    .wr_en(e_we), .wr_addr(e_waddr), .wr_data(e_wdata),
    .busy(busy)
  );

  assign host_rdata = rd_bad_q ? {DW{1'b1}} : a_q;

  AST_BAD_IDX_FLAG: assert property (@(posedge clk) disable iff (rst)
    (data_acc && !idx_valid) |=> host_err); // R4
  AST_GOOD_IDX_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (data_acc && idx_valid) |=> !host_err); // R4
  AST_BAD_READ_ONES: assert property (@(posedge clk) disable iff (rst)
    (data_rd && !idx_valid) |=> (host_rdata == {DW{1'b1}})); // R4
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy); // R6
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !data_acc |=> $stable(host_err)); // R4
endmodule

// File: tb/cmos_nvram_tb.sv
module cmos_nvram_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr = 1'b0, host_rd = 1'b0, host_sel = 1'b0, host_hi_idx = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic       recalc = 1'b0;
  logic [7:0] host_rdata;
  logic       host_err, busy;

  int errors = 0;
  int checks = 0;
  logic [7:0] m [256];

  always #5 clk = ~clk;

  cmos_nvram dut_i (
    .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
    .host_sel(host_sel), .host_hi_idx(host_hi_idx), .host_wdata(host_wdata),
    .recalc(recalc), .host_rdata(host_rdata), .host_err(host_err), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_idx(input bit b, input logic [7:0] off);
    host_wr = 1'b1; host_sel = 1'b0; host_hi_idx = b; host_wdata = off;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic wr_at(input bit b, input logic [7:0] off, input logic [7:0] v);
    set_idx(b, off);
    host_wr = 1'b1; host_sel = 1'b1; host_wdata = v;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd_at(input bit b, input logic [7:0] off, output logic [7:0] v, output logic e);
    set_idx(b, off);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    v = host_rdata;
    e = host_err;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  function automatic int model_sum();
    int s = 0;
    for (int a = 'h10; a <= 'h2D; a++) s += m[a];
    return s & 16'hFFFF;
  endfunction

  task automatic check_ck(input string req);
    logic [7:0] v;
    logic e;
    int s;
    s = model_sum();
    m['h2E] = s[15:8];
    m['h2F] = s[7:0];
    rd_at(0, 8'h2E, v, e);
    chk(v == s[15:8], req, v, s[15:8]);
    rd_at(0, 8'h2F, v, e);
    chk(v == s[7:0], req, v, s[7:0]);
  endtask

  function automatic logic [7:0] pat(input int a, input int k);
    return 8'((a * 37 + k * 11 + 5) & 255);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic e;
    int cnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(host_rdata == 8'h00, "R1", host_rdata, 0);
    chk(host_err == 1'b0, "R1", host_err, 0);
    chk(busy == 1'b0, "R1", busy, 0);

    // R6: fill outside the window, no recompute
    for (int a = 'h0E; a <= 'hFF; a++) begin
      if (a < 'h10 || a > 'h2F) begin
        wr_at(a >= 'h80, 8'(a), pat(a, 0));
        m[a] = pat(a, 0);
        chk(busy == 1'b0, "R6", busy, 0);
      end
    end
    // R10: back-to-back window writes, each restarts the sum
    for (int a = 'h10; a <= 'h2D; a++) begin
      wr_at(0, 8'(a), pat(a, 1));
      m[a] = pat(a, 1);
    end
    wait_idle();
    check_ck("R5");
    // R2 / R3: read back every valid location in both banks
    for (int a = 'h0E; a <= 'hFF; a++) begin
      rd_at(a >= 'h80, 8'(a), v, e);
      chk(v == m[a] && !e, "R3", {e, v}, m[a]);
    end
    // R2: write then immediate read
    wr_at(1, 8'hC3, 8'h5A); m['hC3] = 8'h5A;
    rd_at(1, 8'hC3, v, e);
    chk(v == 8'h5A, "R2", v, 8'h5A);

    // R4: invalid indexes alias real locations; nothing may change
    wr_at(1, 8'h10, 8'hE7);
    chk(host_err == 1'b1, "R4", host_err, 1);
    chk(busy == 1'b0, "R4", busy, 0);
    rd_at(0, 8'h10, v, e);
    chk(v == m['h10], "R4", v, m['h10]);
    chk(e == 1'b0, "R4", e, 0);
    wr_at(0, 8'h80, 8'h3C);
    chk(host_err == 1'b1, "R4", host_err, 1);
    rd_at(1, 8'h80, v, e);
    chk(v == m['h80], "R4", v, m['h80]);
    rd_at(0, 8'h0D, v, e);
    chk(v == 8'hFF && e, "R4", {e, v}, 'h1FF);
    rd_at(1, 8'h7F, v, e);
    chk(v == 8'hFF && e, "R4", {e, v}, 'h1FF);
    rd_at(0, 8'h0E, v, e);
    chk(v == m['h0E] && !e, "R4", {e, v}, m['h0E]);
    check_ck("R4");

    // R6: write outside window, checksum bytes untouched
    wr_at(0, 8'h30, 8'h99); m['h30] = 8'h99;
    repeat (3) begin
      chk(busy == 1'b0, "R6", busy, 0);
      @(negedge clk);
    end
    check_ck("R6");

    // R7: busy duration
    wr_at(0, 8'h18, 8'hF0); m['h18] = 8'hF0;
    cnt = 0;
    while (busy && cnt < 100) begin cnt++; @(negedge clk); end
    chk(cnt == 33, "R7", cnt, 33);
    check_ck("R7");

    // R8: corrupt checksum while idle, then recalc restores it
    wr_at(0, 8'h2F, 8'h00);
    rd_at(0, 8'h2F, v, e);
    chk(v == 8'h00 && busy == 1'b0, "R8", v, 0);
    recalc = 1'b1; @(negedge clk); recalc = 1'b0;
    chk(busy == 1'b1, "R8", busy, 1);
    wait_idle();
    check_ck("R8");

    // R9: checksum-byte writes during busy are discarded
    recalc = 1'b1; @(negedge clk); recalc = 1'b0;
    wr_at(0, 8'h2E, 8'hAB);
    wr_at(0, 8'h2F, 8'hCD);
    chk(busy == 1'b1, "R9", busy, 1);
    wait_idle();
    check_ck("R9");

    // R10: window write mid-recompute restarts the sum
    wr_at(0, 8'h20, 8'h11); m['h20] = 8'h11;
    repeat (12) @(negedge clk);
    wr_at(0, 8'h12, 8'hFE); m['h12] = 8'hFE;
    repeat (25) @(negedge clk);
    wr_at(0, 8'h2D, 8'h77); m['h2D] = 8'h77;
    wait_idle();
    check_ck("R10");

    // R5: all-0xFF window exercises the 16-bit sum width
    for (int a = 'h10; a <= 'h2D; a++) begin
      wr_at(0, 8'(a), 8'hFF); m[a] = 8'hFF;
    end
    wait_idle();
    check_ck("R5");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule